// File: doc/BRIEF.md
# Clock Lane Burst Coordinator

This block sequences the clock lane of a source-synchronous serial link around each high-speed burst. Starting from the idle low-power state, it asks for high-speed mode, runs the clock lane through its own preparation and zero phases, lets the clock toggle for a programmed lead time, and only then grants the data lanes permission to start. Once every enabled data lane reports that its trail has finished, it withdraws the grant and keeps the clock toggling for a programmed tail interval. After that it parks the line at HS-0 for a trail interval and returns to the idle low-power state.

Every interval is a programmable count of controller clock cycles. The clock-toggle lead and tail intervals count cycles in which the toggle enable is high, so each counted cycle stands for one unit interval of the lane clock. A lane-count input enables data lanes 0 through count-1. The trail-done flags of lanes outside that range are ignored. The clock generator and the data-lane sequencers are outside this block.

Top module: `clkln_burst_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `lp_state` is 2'b11 (LP-11, bit 1 is the positive line) and `hs_drive`, `clk_toggle_en` and `data_grant` are all 0.
- R2: A request seen while idle produces LP-01 (`lp_state`=2'b01) for `t_lpx` cycles, followed by LP-00 (`lp_state`=2'b00, `hs_drive`=0) for `t_prepare` cycles.
- R3: After the prepare phase, the lane drives HS-0 (`hs_drive`=1, `clk_toggle_en`=0, `lp_state`=2'b00) for `t_zero` cycles.
- R4: After the zero phase, `clk_toggle_en` is 1 with `data_grant` at 0 for `t_pre` cycles. `data_grant` goes to 1 in the cycle that follows.
- R5: `data_grant` stays at 1 until every lane i with i < `lane_count` has `trail_done[i]` high. Flags of lanes at or above `lane_count` have no effect.
- R6: In the cycle after all enabled lanes report done, `data_grant` is 0. `clk_toggle_en` then stays at 1 for `t_post` cycles.
- R7: After the tail interval, the lane drives HS-0 for `t_trail` cycles and then LP-11 for `t_lpx` cycles, during which no request is taken. If a request is high when that interval ends, LP-01 follows with no extra idle cycle.
- R8: A request that rises and falls while a burst is in progress has no effect. After that burst, the lane stays at LP-11 until a new request arrives.
- R9: An interval programmed as 0 lasts one cycle, the same as an interval of 1.
- R10: `data_grant` is 1 only while `clk_toggle_en` and `hs_drive` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_req | input | 1 | Level request for a high-speed burst |
| lane_count | input | LANE_W | Number of enabled data lanes, counted from lane 0 |
| trail_done | input | NUM_LANES | Per-lane flag: the data lane has finished its trail |
| t_lpx | input | CNT_W | Length of each low-power phase (LP-01 and exit LP-11) |
| t_prepare | input | CNT_W | Length of the LP-00 prepare phase |
| t_zero | input | CNT_W | Length of the HS-0 phase before toggling |
| t_pre | input | CNT_W | Toggling cycles before the data grant |
| t_post | input | CNT_W | Toggling cycles after the data lanes finish |
| t_trail | input | CNT_W | Length of the HS-0 phase after toggling stops |
| lp_state | output | 2 | Low-power line levels {positive, negative}; 2'b00 while high-speed drivers are on |
| hs_drive | output | 1 | High-speed driver enabled |
| clk_toggle_en | output | 1 | Clock toggling enabled |
| data_grant | output | 1 | Data lanes may begin their transition to high-speed |

## Verification
There are two places where one cycle can carry two events. In the first, the lead interval expires in the same cycle that the data lanes already report done. The bench sets every enabled trail flag during the lead interval. It then expects exactly one cycle of grant, followed by the tail interval, so that a grant is never skipped. In the second, the exit low-power interval expires in the same cycle that a new request is high. The bench holds the request through the end of the burst. It expects LP-01 to follow the exit interval directly, and it measures the exit length to the exact cycle. Randomly drawn intervals, including 0, and random lane counts exercise both cases across many burst shapes.

// File: rtl/clkln_pkg.sv
package clkln_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_PREP,
        ST_ZERO,
        ST_PRE,
        ST_RUN,
        ST_POST,
        ST_TRAIL,
        ST_EXIT
    } clk_state_e;

    typedef struct packed {
        logic [1:0] lp;
        logic       hs;
        logic       tog;
        logic       grant;
    } lane_drive_t;

    localparam logic [1:0] LINE_LP11 = 2'b11;
    localparam logic [1:0] LINE_LP01 = 2'b01;
    localparam logic [1:0] LINE_LP00 = 2'b00;

    function automatic lane_drive_t drive_of(clk_state_e s);
        lane_drive_t d;
        d = '{lp: LINE_LP00, hs: 1'b0, tog: 1'b0, grant: 1'b0};
        case (s)
            ST_IDLE, ST_EXIT: d.lp = LINE_LP11;
            ST_REQ:           d.lp = LINE_LP01;
            ST_PREP:          d.lp = LINE_LP00;
            ST_ZERO, ST_TRAIL: d.hs = 1'b1;
            ST_PRE, ST_POST: begin
                d.hs  = 1'b1;
                d.tog = 1'b1;
            end
            ST_RUN: begin
                d.hs    = 1'b1;
                d.tog   = 1'b1;
                d.grant = 1'b1;
            end
            default:          d.lp = LINE_LP11;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/clkln_interval_timer.sv
module clkln_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Reaches expiry once cnt+1 covers the limit; a limit of 0 acts as 1.
    assign expired = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/clkln_trail_monitor.sv
module clkln_trail_monitor #(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 3
) (
    input  logic [LANE_W-1:0]    lane_count,
    input  logic [NUM_LANES-1:0] trail_done,
    output logic                 all_done
);

    logic [NUM_LANES-1:0] lane_ok;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        // Lanes outside the enabled range never hold back the tail phase.
        assign lane_ok[i] = trail_done[i] || !(lane_count > LANE_W'(i));
    end

    assign all_done = &lane_ok;

endmodule

// File: rtl/clkln_sequencer.sv
module clkln_sequencer
    import clkln_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             burst_req,
    input  logic             all_done,
    input  logic             expired,
    input  logic [CNT_W-1:0] t_lpx,
    input  logic [CNT_W-1:0] t_prepare,
    input  logic [CNT_W-1:0] t_zero,
    input  logic [CNT_W-1:0] t_pre,
    input  logic [CNT_W-1:0] t_post,
    input  logic [CNT_W-1:0] t_trail,
    output logic             restart,
    output logic [CNT_W-1:0] limit,
    output lane_drive_t      drive
);

    clk_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (burst_req) nxt = ST_REQ;
            ST_REQ:   if (expired)   nxt = ST_PREP;
            ST_PREP:  if (expired)   nxt = ST_ZERO;
            ST_ZERO:  if (expired)   nxt = ST_PRE;
            ST_PRE:   if (expired)   nxt = ST_RUN;
            ST_RUN:   if (all_done)  nxt = ST_POST;
            ST_POST:  if (expired)   nxt = ST_TRAIL;
            ST_TRAIL: if (expired)   nxt = ST_EXIT;
            ST_EXIT:  if (expired)   nxt = burst_req ? ST_REQ : ST_IDLE;
            default:                 nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_PREP:  limit = t_prepare;
            ST_ZERO:  limit = t_zero;
            ST_PRE:   limit = t_pre;
            ST_POST:  limit = t_post;
            ST_TRAIL: limit = t_trail;
            default:  limit = t_lpx;
        endcase
    end

    assign restart = (nxt != state);
    assign drive   = drive_of(state);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R5: grant is held while any enabled lane is still busy
    p_run_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !all_done) |=> (state == ST_RUN));

    // R6: all lanes done moves straight into the tail interval
    p_post_follows_done_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && all_done) |=> (state == ST_POST && !drive.grant));

    // R4: grant only rises once the lead interval has expired
    p_grant_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(drive.grant) |-> ($past(state) == ST_PRE && $past(expired)));

    // R7: no request accepted before the exit interval ends
    p_exit_blocks_req_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXIT && !expired) |=> (state == ST_EXIT));

    // R8: idle stays idle without a request
    p_idle_waits_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !burst_req) |=> (state == ST_IDLE));

endmodule

// File: rtl/clkln_burst_ctrl.sv
module clkln_burst_ctrl
    import clkln_pkg::*;
#(
    parameter int  NUM_LANES = 4,
    parameter int  CNT_W     = 8,
    localparam int LANE_W    = $clog2(NUM_LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 burst_req,
    input  logic [LANE_W-1:0]    lane_count,
    input  logic [NUM_LANES-1:0] trail_done,
    input  logic [CNT_W-1:0]     t_lpx,
    input  logic [CNT_W-1:0]     t_prepare,
    input  logic [CNT_W-1:0]     t_zero,
    input  logic [CNT_W-1:0]     t_pre,
    input  logic [CNT_W-1:0]     t_post,
    input  logic [CNT_W-1:0]     t_trail,
    output logic [1:0]           lp_state,
    output logic                 hs_drive,
    output logic                 clk_toggle_en,
    output logic                 data_grant
);

    logic             all_done;
    logic             expired;
    logic             restart;
    logic [CNT_W-1:0] limit;
    lane_drive_t      drive;

    clkln_trail_monitor #(
        .NUM_LANES (NUM_LANES),
        .LANE_W    (LANE_W)
    ) i_monitor (
        .lane_count (lane_count),
        .trail_done (trail_done),
        .all_done   (all_done)
    );

    clkln_interval_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .limit   (limit),
        .expired (expired)
    );

    clkln_sequencer #(
        .CNT_W (CNT_W)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .burst_req (burst_req),
        .all_done  (all_done),
        .expired   (expired),
        .t_lpx     (t_lpx),
        .t_prepare (t_prepare),
        .t_zero    (t_zero),
        .t_pre     (t_pre),
        .t_post    (t_post),
        .t_trail   (t_trail),
        .restart   (restart),
        .limit     (limit),
        .drive     (drive)
    );

    assign lp_state      = drive.lp;
    assign hs_drive      = drive.hs;
    assign clk_toggle_en = drive.tog;
    assign data_grant    = drive.grant;

    // R10: a grant never appears without a running high-speed clock
    p_grant_has_clock_r10: assert property (@(posedge clk) disable iff (rst)
        data_grant |-> (clk_toggle_en && hs_drive));

    // R1: the cycle after reset shows idle LP-11 and nothing driven
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lp_state == LINE_LP11 && !hs_drive && !clk_toggle_en && !data_grant));

endmodule

// File: tb/test_clkln_burst_ctrl.sv
`timescale 1ns/1ps
module test_clkln_burst_ctrl;

    localparam int NL = 4;
    localparam int CW = 8;
    localparam int LW = $clog2(NL + 1);

    localparam int P_LP11  = 0;
    localparam int P_LP01  = 1;
    localparam int P_LP00  = 2;
    localparam int P_HS0   = 3;
    localparam int P_TOG   = 4;
    localparam int P_GRANT = 5;
    localparam int P_BAD   = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          burst_req = 1'b0;
    logic [LW-1:0] lane_count = LW'(1);
    logic [NL-1:0] trail_done = '0;
    logic [CW-1:0] t_lpx = 8'd2, t_prepare = 8'd2, t_zero = 8'd2;
    logic [CW-1:0] t_pre = 8'd8, t_post = 8'd4, t_trail = 8'd3;
    logic [1:0]    lp_state;
    logic          hs_drive, clk_toggle_en, data_grant;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    clkln_burst_ctrl #(.NUM_LANES(NL), .CNT_W(CW)) i_clkln_burst_ctrl (
        .clk           (clk),
        .rst           (rst),
        .burst_req     (burst_req),
        .lane_count    (lane_count),
        .trail_done    (trail_done),
        .t_lpx         (t_lpx),
        .t_prepare     (t_prepare),
        .t_zero        (t_zero),
        .t_pre         (t_pre),
        .t_post        (t_post),
        .t_trail       (t_trail),
        .lp_state      (lp_state),
        .hs_drive      (hs_drive),
        .clk_toggle_en (clk_toggle_en),
        .data_grant    (data_grant)
    );

    function automatic int pat();
        if (!hs_drive && !clk_toggle_en && !data_grant) begin
            if (lp_state == 2'b11) return P_LP11;
            if (lp_state == 2'b01) return P_LP01;
            if (lp_state == 2'b00) return P_LP00;
            return P_BAD;
        end
        if (lp_state != 2'b00) return P_BAD;
        if (hs_drive && !clk_toggle_en && !data_grant) return P_HS0;
        if (hs_drive && clk_toggle_en && !data_grant) return P_TOG;
        if (hs_drive && clk_toggle_en && data_grant) return P_GRANT;
        return P_BAD;
    endfunction

    function automatic int eff(int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic logic [NL-1:0] lane_mask(int n);
        return NL'((1 << n) - 1);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Checks the visible pattern for len cycles, ending on the next phase's first cycle.
    task automatic expect_run(int code, int len, string tag);
        for (int i = 0; i < len; i++) begin
            check(pat() == code, tag, pat(), code);
            @(negedge clk);
        end
    endtask

    task automatic burst(int n, bit started, bit b2b, bit early_done, bit stray_req);
        lane_count = LW'(n);
        if (!started) begin
            burst_req  = 1'b1;
            trail_done = '0;
            @(negedge clk);
        end
        expect_run(P_LP01, eff(int'(t_lpx)),     "R2 request LP-01");
        expect_run(P_LP00, eff(int'(t_prepare)), "R2 prepare LP-00");
        expect_run(P_HS0,  eff(int'(t_zero)),    "R3 zero HS-0");
        if (early_done) trail_done = lane_mask(n);
        expect_run(P_TOG,  eff(int'(t_pre)),     "R4 lead toggling");
        burst_req = 1'b0;
        if (early_done) begin
            expect_run(P_GRANT, 1, "R4 single grant with early done");
        end else begin
            expect_run(P_GRANT, 1, "R4 grant after lead");
            if (stray_req) burst_req = 1'b1;
            expect_run(P_GRANT, $urandom_range(0, 3), "R5 grant held");
            burst_req  = 1'b0;
            trail_done = ~lane_mask(n);
            expect_run(P_GRANT, 2, "R5 disabled lanes ignored");
            if (n > 1) begin
                trail_done = ~lane_mask(n) | lane_mask(n - 1);
                expect_run(P_GRANT, 2, "R5 partial lanes hold grant");
            end
            trail_done = '1;
            expect_run(P_GRANT, 1, "R6 last grant cycle");
        end
        trail_done = '0;
        if (b2b) burst_req = 1'b1;
        check(!data_grant, "R6 grant withdrawn", int'(data_grant), 0);
        expect_run(P_TOG,  eff(int'(t_post)),  "R6 tail toggling");
        expect_run(P_HS0,  eff(int'(t_trail)), "R7 trail HS-0");
        expect_run(P_LP11, eff(int'(t_lpx)),   "R7 exit LP-11");
        if (b2b) check(pat() == P_LP01, "R7 back-to-back request", pat(), P_LP01);
        else     expect_run(P_LP11, 6, "R8 stays idle");
    endtask

    task automatic set_times(int a, int b, int c, int d, int e, int f);
        t_lpx = CW'(a); t_prepare = CW'(b); t_zero = CW'(c);
        t_pre = CW'(d); t_post = CW'(e);    t_trail = CW'(f);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(pat() == P_LP11, "R1 state during reset", pat(), P_LP11);
        rst = 1'b0;
        @(negedge clk);
        check(pat() == P_LP11, "R1 state after reset", pat(), P_LP11);
        check(!data_grant, "R1 grant low after reset", int'(data_grant), 0);
        expect_run(P_LP11, 3, "R8 idle without request");

        // Directed: nominal four-lane burst with a stray request pulse
        set_times(2, 3, 2, 8, 4, 3);
        burst(4, 1'b0, 1'b0, 1'b0, 1'b1);
        // Directed: every interval zero (R9), single lane
        set_times(0, 0, 0, 0, 0, 0);
        burst(1, 1'b0, 1'b0, 1'b0, 1'b0);
        // Directed: lanes done before the lead interval ends
        set_times(1, 2, 1, 3, 2, 2);
        burst(2, 1'b0, 1'b0, 1'b1, 1'b0);
        // Directed: request held across exit, two bursts chained
        set_times(3, 1, 2, 4, 2, 1);
        burst(3, 1'b0, 1'b1, 1'b0, 1'b0);
        burst(3, 1'b1, 1'b0, 1'b0, 1'b0);

        begin
            bit chained = 1'b0;
            for (int k = 0; k < 16; k++) begin
                bit b2b;
                if (!chained)
                    set_times($urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6),
                              $urandom_range(0, 10), $urandom_range(0, 6), $urandom_range(0, 6));
                b2b = (k < 15) && ($urandom_range(0, 1) == 1);
                burst($urandom_range(1, NL), chained, b2b,
                      $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
                chained = b2b;
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule